// File: doc/BRIEF.md
# DMA Interrupt and Channel-Enable Register Bank

This block is the register bank that holds the interrupt state and the channel enables of an eight-channel DMA controller. Each channel reports five kinds of event as one-cycle pulses: chain transfer complete, block complete, source transaction, destination transaction and bus error. The bank latches every pulse into a sticky raw bit. It gates the raw bits with a per-type mask to give a status word, and it lets software acknowledge the raw bits with write-one-to-clear accesses. All of this is reached through a plain 32-bit register port with a word address. Writes take effect at the clock edge. Reads are combinational and have no side effects.

The mask registers and the channel-enable register use a write-enable-per-bit scheme. The upper byte of the write data picks which channel bits of the lower byte are updated, so software can change one channel without a read-modify-write. A channel-enable bit drops by itself when that channel's chain completes. A global enable bit gates all channel enables. The bank drives one combined interrupt line and offers a read-only summary showing which event types have a pending status bit.

Top module: `dma_irq_regbank`

## Requirements
- R1: After reset every raw, mask, channel-enable and global-enable bit is 0, the interrupt output is 0 and every register reads as 0.
- R2: An event pulse on a channel sets that channel's raw bit for that event type at the next clock edge, whatever the mask holds. The bit stays set until it is cleared.
- R3: A status register (word address 0x08+t) reads as the raw register of type t ANDed with the mask of type t. Changing a mask never alters the raw bits. Type index t is 0 chain complete, 1 block complete, 2 source transaction, 3 destination transaction, 4 bus error. Raw registers sit at 0x00+t.
- R4: Writing to a clear register (0x18+t) clears the raw bits whose data bit is 1 and leaves the bits whose data bit is 0. If an event and a clear hit the same bit in the same cycle, the bit ends up set. Clear registers read as 0.
- R5: A mask write (0x10+t) updates channel bit c to data bit c only where data bit 8+c is 1. Mask reads return the mask in bits 7:0 and zero above.
- R6: A channel-enable write (0x22) uses the same per-bit write-enable scheme. It reads back in bits 7:0 and is driven on chan_en.
- R7: A chain-complete pulse on channel c clears channel-enable bit c at the next edge. This wins over a write that sets the bit in the same cycle.
- R8: Bit 0 of the global configuration register (0x21) is the global enable. Other bits read as 0. While the global enable is 0, all channel-enable bits are 0 and channel-enable writes have no effect. A write that clears the global enable clears all channel enables at the same edge.
- R9: The summary register (0x20) has bit t set when status register t is nonzero. irq is 1 when any status bit is set.
- R10: Raw, status and summary registers are read-only, and writes to them are ignored. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ev_tfr | input | NCH | Chain-complete pulses, one per channel |
| ev_blk | input | NCH | Block-complete pulses |
| ev_src | input | NCH | Source-transaction pulses |
| ev_dst | input | NCH | Destination-transaction pulses |
| ev_err | input | NCH | Bus-error pulses |
| irq | output | 1 | Combined interrupt |
| glb_en | output | 1 | Global enable |
| chan_en | output | NCH | Channel enables |

## Verification
Every stored bit is visible one clock edge after it changes: raw and mask bits through their read addresses, enables on chan_en and glb_en, and gating errors on irq and the summary word. A lost or stuck raw bit therefore shows in the very next read of its raw word, and also in the status word, the summary word and irq when its mask is set. A wrong write-enable merge shows as a neighbouring channel bit changing in the mask or enable read-back. Same-cycle collisions between an event and a clear, or between a completion and a set, are driven on purpose, because a wrong priority shows only in the cycle right after the collision.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NSRC   = 5;
  localparam int ADDR_W = 6;

  localparam int RAW_BASE  = 'h00;
  localparam int STAT_BASE = 'h08;
  localparam int MASK_BASE = 'h10;
  localparam int CLR_BASE  = 'h18;
  localparam int ADDR_SUM  = 'h20;
  localparam int ADDR_GCFG = 'h21;
  localparam int ADDR_CHEN = 'h22;

  typedef struct packed {
    logic [NSRC-1:0] clr_sel;
    logic [NSRC-1:0] mask_sel;
    logic            gcfg_sel;
    logic            chen_sel;
  } wr_dec_t;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/dma_wr_decode.sv
module dma_wr_decode
  import dma_irq_pkg::*;
(
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output wr_dec_t           dec
);
  always_comb begin
    dec = '0;
    for (int t = 0; t < NSRC; t++) begin
      dec.clr_sel[t]  = wr && (addr == ADDR_W'(CLR_BASE + t));
      dec.mask_sel[t] = wr && (addr == ADDR_W'(MASK_BASE + t));
    end
    dec.gcfg_sel = wr && (addr == ADDR_W'(ADDR_GCFG));
    dec.chen_sel = wr && (addr == ADDR_W'(ADDR_CHEN));
  end
endmodule

// File: rtl/dma_irq_source.sv
module dma_irq_source #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev,
  input  logic           clr_wr,
  input  logic           mask_wr,
  input  logic [2*NCH-1:0] wdata,
  output logic [NCH-1:0] raw,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] status
);
  logic [NCH-1:0] raw_q, raw_d, mask_q, mask_d;
  logic [NCH-1:0] wval, wsel, clr_bits;
  logic           raw_en, mask_en;

  assign wval = wdata[NCH-1:0];
  assign wsel = wdata[2*NCH-1:NCH];

  always_comb begin
    clr_bits = clr_wr ? wval : '0;
    raw_d    = (raw_q & ~clr_bits) | ev;
    raw_en   = clr_wr | (|ev);
    mask_d   = (mask_q & ~wsel) | (wval & wsel);
    mask_en  = mask_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      if (raw_en)  raw_q  <= raw_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign status = raw_q & mask_q;
endmodule

// File: rtl/dma_chan_enable.sv
module dma_chan_enable #(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gcfg_wr,
  input  logic             chen_wr,
  input  logic [2*NCH-1:0] wdata,
  input  logic [NCH-1:0]   done,
  output logic             glb_en,
  output logic [NCH-1:0]   chen
);
  logic           glb_q, glb_d, glb_ce;
  logic [NCH-1:0] chen_q, chen_d, merged, wval, wsel;
  logic           chen_ce;

  assign wval = wdata[NCH-1:0];
  assign wsel = wdata[2*NCH-1:NCH];

  always_comb begin
    glb_d   = gcfg_wr ? wdata[0] : glb_q;
    glb_ce  = gcfg_wr;
    merged  = chen_wr ? ((chen_q & ~wsel) | (wval & wsel)) : chen_q;
    chen_d  = glb_d ? (merged & ~done) : '0;
    chen_ce = chen_wr | gcfg_wr | (|done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q  <= 1'b0;
      chen_q <= '0;
    end else begin
      if (glb_ce)  glb_q  <= glb_d;
      if (chen_ce) chen_q <= chen_d;
    end
  end

  assign glb_en = glb_q;
  assign chen   = chen_q;
endmodule

// File: rtl/dma_read_mux.sv
module dma_read_mux
  import dma_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NSRC*NCH-1:0] raw_all,
  input  logic [NSRC*NCH-1:0] mask_all,
  input  logic [NSRC*NCH-1:0] stat_all,
  input  logic [NSRC-1:0]     summary,
  input  logic                glb_en,
  input  logic [NCH-1:0]      chen,
  output logic [31:0]         rdata
);
  always_comb begin
    rdata = '0;
    for (int t = 0; t < NSRC; t++) begin
      if (addr == ADDR_W'(RAW_BASE + t))  rdata[NCH-1:0] = raw_all[t*NCH +: NCH];
      if (addr == ADDR_W'(STAT_BASE + t)) rdata[NCH-1:0] = stat_all[t*NCH +: NCH];
      if (addr == ADDR_W'(MASK_BASE + t)) rdata[NCH-1:0] = mask_all[t*NCH +: NCH];
    end
    if (addr == ADDR_W'(ADDR_SUM))  rdata[NSRC-1:0] = summary;
    if (addr == ADDR_W'(ADDR_GCFG)) rdata[0]        = glb_en;
    if (addr == ADDR_W'(ADDR_CHEN)) rdata[NCH-1:0]  = chen;
  end
endmodule

// File: rtl/dma_irq_regbank.sv
module dma_irq_regbank
  import dma_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    ev_tfr,
  input  logic [NCH-1:0]    ev_blk,
  input  logic [NCH-1:0]    ev_src,
  input  logic [NCH-1:0]    ev_dst,
  input  logic [NCH-1:0]    ev_err,
  output logic              irq,
  output logic              glb_en,
  output logic [NCH-1:0]    chan_en
);
  localparam int WD_W = 2 * NCH;

  logic                rst_q_n;
  wr_dec_t             dec;
  logic [NSRC*NCH-1:0] ev_all, raw_all, mask_all, stat_all;
  logic [NSRC-1:0]     summary;
  logic [WD_W-1:0]     wd_lo;
  logic                wdata_unused;

  assign ev_all       = {ev_err, ev_dst, ev_src, ev_blk, ev_tfr};
  assign wd_lo        = bus_wdata[WD_W-1:0];
  assign wdata_unused = ^bus_wdata[31:WD_W];

  dma_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  dma_wr_decode u_dec (.wr(bus_wr), .addr(bus_addr), .dec(dec));

  for (genvar t = 0; t < NSRC; t++) begin : g_src
    dma_irq_source #(.NCH(NCH)) u_src (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .ev     (ev_all[t*NCH +: NCH]),
      .clr_wr (dec.clr_sel[t]),
      .mask_wr(dec.mask_sel[t]),
      .wdata  (wd_lo),
      .raw    (raw_all[t*NCH +: NCH]),
      .mask   (mask_all[t*NCH +: NCH]),
      .status (stat_all[t*NCH +: NCH])
    );
    assign summary[t] = |stat_all[t*NCH +: NCH];
  end

  dma_chan_enable #(.NCH(NCH)) u_chen (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .gcfg_wr(dec.gcfg_sel),
    .chen_wr(dec.chen_sel),
    .wdata  (wd_lo),
    .done   (ev_tfr),
    .glb_en (glb_en),
    .chen   (chan_en)
  );

  dma_read_mux #(.NCH(NCH)) u_rd (
    .addr    (bus_addr),
    .raw_all (raw_all),
    .mask_all(mask_all),
    .stat_all(stat_all),
    .summary (summary),
    .glb_en  (glb_en),
    .chen    (chan_en),
    .rdata   (bus_rdata)
  );

  assign irq = |summary;
endmodule

// File: rtl/dma_irq_regbank_chk.sv
module dma_irq_regbank_chk
  import dma_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic [NSRC*NCH-1:0] ev_all,
  input logic [NSRC*NCH-1:0] raw_all,
  input logic [NSRC*NCH-1:0] mask_all,
  input logic [NCH-1:0]      ev_tfr,
  input logic [NCH-1:0]      chan_en,
  input logic                glb_en,
  input logic                irq
);
  p_raw_latch_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> ((raw_all & $past(ev_all)) == $past(ev_all)));

  p_irq_masked_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq == (|(raw_all & mask_all)));

  p_chen_done_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|ev_tfr) |=> ((chan_en & $past(ev_tfr)) == '0));

  p_glb_gate_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !glb_en |-> (chan_en == '0));

  p_no_raw_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (raw_all == '0) |-> !irq);
endmodule

bind dma_irq_regbank dma_irq_regbank_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .ev_all  (ev_all),
  .raw_all (raw_all),
  .mask_all(mask_all),
  .ev_tfr  (ev_tfr),
  .chan_en (chan_en),
  .glb_en  (glb_en),
  .irq     (irq)
);

// File: tb/dma_irq_regbank_test.sv
module dma_irq_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 25;

  logic        clk, rst_n, bus_wr, irq, glb_en;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  ev_tfr, ev_blk, ev_src, ev_dst, ev_err, chan_en;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // entry: {write, addr, data_or_expected, requirement number (0 for writes)}
  localparam logic [46:0] VEC [0:NVEC-1] = '{
    {1'b0, 6'h10, 32'h0000_0000, 8'd1},   // R1 mask reset
    {1'b1, 6'h10, 32'h0000_00FF, 8'd0},
    {1'b0, 6'h10, 32'h0000_0000, 8'd5},   // R5 no write enables, no change
    {1'b1, 6'h10, 32'h0000_0F0F, 8'd0},
    {1'b0, 6'h10, 32'h0000_000F, 8'd5},   // R5
    {1'b1, 6'h10, 32'h0000_0300, 8'd0},
    {1'b1, 6'h10, 32'h0000_F0F0, 8'd0},
    {1'b0, 6'h10, 32'h0000_00FC, 8'd5},   // R5 partial updates
    {1'b1, 6'h14, 32'hFFFF_FFFF, 8'd0},
    {1'b0, 6'h14, 32'h0000_00FF, 8'd5},   // R5 upper bits read zero
    {1'b1, 6'h22, 32'h0000_0101, 8'd0},
    {1'b0, 6'h22, 32'h0000_0000, 8'd8},   // R8 enable write ignored while off
    {1'b1, 6'h21, 32'h0000_0001, 8'd0},
    {1'b0, 6'h21, 32'h0000_0001, 8'd8},   // R8
    {1'b1, 6'h22, 32'h0000_FFAA, 8'd0},
    {1'b0, 6'h22, 32'h0000_00AA, 8'd6},   // R6
    {1'b1, 6'h22, 32'h0000_0F00, 8'd0},
    {1'b0, 6'h22, 32'h0000_00A0, 8'd6},   // R6
    {1'b1, 6'h00, 32'h0000_00FF, 8'd0},
    {1'b0, 6'h00, 32'h0000_0000, 8'd10},  // R10 raw is read-only
    {1'b0, 6'h18, 32'h0000_0000, 8'd4},   // R4 clear reads zero
    {1'b0, 6'h3F, 32'h0000_0000, 8'd10},  // R10 unmapped
    {1'b1, 6'h21, 32'h0000_0000, 8'd0},
    {1'b0, 6'h22, 32'h0000_0000, 8'd8},   // R8 global off clears enables
    {1'b0, 6'h08, 32'h0000_0000, 8'd1}    // R1 status reset
  };

  dma_irq_regbank #(.NCH(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_tfr(ev_tfr),
    .ev_blk(ev_blk), .ev_src(ev_src), .ev_dst(ev_dst), .ev_err(ev_err),
    .irq(irq), .glb_en(glb_en), .chan_en(chan_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; drives one cycle and returns at the next falling edge
  task automatic step(input logic wr, input logic [5:0] a, input logic [31:0] d,
                      input logic [7:0] etf, input logic [7:0] ebl,
                      input logic [7:0] esr, input logic [7:0] eer);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    ev_tfr = etf; ev_blk = ebl; ev_src = esr; ev_err = eer;
    @(negedge clk);
    bus_wr = 1'b0; ev_tfr = '0; ev_blk = '0; ev_src = '0; ev_err = '0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    step(1'b1, a, d, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    ev_tfr = '0; ev_blk = '0; ev_src = '0; ev_dst = '0; ev_err = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 chan_en", {24'b0, chan_en}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][46]) wr(VEC[i][45:40], VEC[i][39:8]);
      else rd(VEC[i][45:40], VEC[i][39:8], $sformatf("R%0d vec%0d", VEC[i][7:0], i));
    end

    // events latch regardless of mask
    step(1'b0, 6'h00, 32'h0, 8'h81, 8'h00, 8'h00, 8'h02);
    rd(6'h00, 32'h81, "R2 raw chain");
    rd(6'h04, 32'h02, "R2 raw error");
    rd(6'h08, 32'h80, "R3 status chain");
    rd(6'h0C, 32'h02, "R3 status error");
    rd(6'h20, 32'h11, "R9 summary");
    chk("R9 irq", {31'b0, irq}, 32'h1);
    wr(6'h10, 32'h0000_FF00);
    rd(6'h00, 32'h81, "R3 mask leaves raw");
    rd(6'h08, 32'h00, "R3 status after mask off");
    rd(6'h20, 32'h10, "R9 summary error only");

    // clear semantics
    wr(6'h18, 32'h01);
    rd(6'h00, 32'h80, "R4 clear one");
    wr(6'h18, 32'h00);
    rd(6'h00, 32'h80, "R4 clear zero no effect");
    step(1'b1, 6'h19, 32'h04, 8'h00, 8'h04, 8'h00, 8'h00);
    rd(6'h01, 32'h04, "R4 event beats clear");
    wr(6'h19, 32'hFF);
    rd(6'h01, 32'h00, "R4 clear block");
    wr(6'h18, 32'hFF);
    wr(6'h1C, 32'hFF);
    chk("R9 irq after clears", {31'b0, irq}, 32'h0);
    rd(6'h20, 32'h00, "R9 summary empty");

    // masked-off event then unmask
    step(1'b0, 6'h00, 32'h0, 8'h00, 8'h00, 8'h10, 8'h00);
    rd(6'h02, 32'h10, "R2 raw source");
    rd(6'h0A, 32'h00, "R3 status source masked");
    chk("R3 irq masked", {31'b0, irq}, 32'h0);
    wr(6'h12, 32'h0000_1010);
    rd(6'h0A, 32'h10, "R3 status source unmasked");
    rd(6'h20, 32'h04, "R9 summary source");
    chk("R9 irq source", {31'b0, irq}, 32'h1);
    wr(6'h1A, 32'hFF);
    chk("R4 irq cleared", {31'b0, irq}, 32'h0);

    // self clearing enables
    wr(6'h21, 32'h1);
    wr(6'h22, 32'h0000_FFFF);
    chk("R6 chan_en all", {24'b0, chan_en}, 32'hFF);
    step(1'b0, 6'h00, 32'h0, 8'h05, 8'h00, 8'h00, 8'h00);
    chk("R7 self clear", {24'b0, chan_en}, 32'hFA);
    rd(6'h22, 32'hFA, "R7 read back");
    step(1'b1, 6'h22, 32'h0000_0101, 8'h01, 8'h00, 8'h00, 8'h00);
    chk("R7 done beats set", {24'b0, chan_en}, 32'hFA);
    rd(6'h00, 32'h05, "R2 raw chain again");

    // global off
    wr(6'h21, 32'hFFFF_FFFE);
    chk("R8 glb_en off", {31'b0, glb_en}, 32'h0);
    chk("R8 chan_en forced", {24'b0, chan_en}, 32'h0);
    rd(6'h21, 32'h0, "R8 gcfg read");
    wr(6'h21, 32'hFFFF_FFFF);
    rd(6'h21, 32'h1, "R8 gcfg only bit0");

    // reset mid-run
    wr(6'h22, 32'h0000_0303);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    rd(6'h00, 32'h0, "R1 raw after reset");
    rd(6'h14, 32'h0, "R1 mask after reset");
    chk("R1 glb_en after reset", {31'b0, glb_en}, 32'h0);
    chk("R1 chan_en after reset", {24'b0, chan_en}, 32'h0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule